// File: doc/BRIEF.md
# Fracturable LUT logic element

This block is one logic element of a programmable fabric. It holds a single 64-bit truth table, which it can use in two ways. It can act as one 6-input function. It can also act as two independent 5-input functions that share the five low data inputs. A mode bit in the configuration picks the use. The hardware is the same in both modes, and each mode simply uses part of it.

Configuration is loaded through a write-enable port that carries three things: the truth table, the mode bit, and one register-select bit per output. Software normally writes it once and then leaves it alone. At run time the six data inputs address the table. Each of the two outputs shows either the table result directly or the value its flip-flop captured at the last rising edge.

Top module: `frac_lut_cell`

## Requirements
- R1: A synchronous active-high reset clears the truth table, the mode bit (to dual), the select bits and both flip-flops to 0. After reset, both outputs read 0 for any data input.
- R2: When `cfg_we` is 1 at a rising edge, `cfg_table`, `cfg_mode` and `cfg_regsel` are stored and take effect from the next cycle. When `cfg_we` is 0, values on those pins have no effect.
- R3: In dual mode (`cfg_mode`=0), `dout[0]` is truth-table bit `din[4:0]` and `dout[1]` is bit `32+din[4:0]`. `din[5]` has no effect.
- R4: In single mode (`cfg_mode`=1), `dout[0]` is truth-table bit `{din[5],din[4:0]}`. That is bit `din`, read as an unsigned 6-bit number.
- R5: In single mode, `dout[1]` is truth-table bit `32+din[4:0]`, the upper-half result.
- R6: When `cfg_regsel[i]` is 1, `dout[i]` shows the LUT result `i` that was present just before the previous rising edge.
- R7: When `cfg_regsel[i]` is 0, `dout[i]` equals LUT result `i` in the same cycle, with no register in the path.
- R8: Both flip-flops capture on every rising edge, whatever the select bits are. On the edge that loads a new configuration, they capture the result computed with the old configuration.
- R9: If reset and `cfg_we` are both 1 at the same edge, reset wins and nothing is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_table | input | 64 | Truth table; bit index equals table address |
| cfg_mode | input | 1 | 0 = two 5-input tables, 1 = one 6-input table |
| cfg_regsel | input | 2 | Bit i selects the registered path for dout[i] |
| din | input | 6 | Data inputs addressing the table |
| dout | output | 2 | Element outputs |

## Verification
A configuration load and a flip-flop capture happen at the same rising edge. The bench drives every new configuration while data inputs are live. It then checks that, in the following cycle, the combinational output already follows the new table while the registered output still shows the old table's result for the load-cycle input. The bench also applies reset and a load in the same cycle, and checks that the outputs afterwards stay at zero.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic {
    MODE_DUAL   = 1'b0,
    MODE_SINGLE = 1'b1
  } flc_mode_e;

  localparam int FLC_NOUT = 2;
endpackage

// File: rtl/flc_cfg_store.sv
module flc_cfg_store
  import flc_pkg::*;
#(
  parameter  int K    = 6,
  parameter  int NOUT = FLC_NOUT,
  localparam int TW   = 1 << K
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [TW-1:0]   wr_table,
  input  logic            wr_mode,
  input  logic [NOUT-1:0] wr_regsel,
  output logic [TW-1:0]   tbl,
  output flc_mode_e       mode,
  output logic [NOUT-1:0] regsel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl    <= '0;
      mode   <= MODE_DUAL;
      regsel <= '0;
    end else if (we) begin
      tbl    <= wr_table;
      mode   <= flc_mode_e'(wr_mode);
      regsel <= wr_regsel;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(tbl) && $stable(mode) && $stable(regsel))); // R2

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> (tbl == $past(wr_table) && regsel == $past(wr_regsel))); // R2

endmodule

// File: rtl/flc_half_lut.sv
module flc_half_lut #(
  parameter  int HK = 5,
  localparam int HW = 1 << HK
) (
  input  logic [HW-1:0] tbl,
  input  logic [HK-1:0] addr,
  output logic          q
);
  assign q = tbl[addr];
endmodule

// File: rtl/flc_lut_core.sv
module flc_lut_core
  import flc_pkg::*;
#(
  parameter  int K  = 6,
  localparam int TW = 1 << K,
  localparam int HK = K - 1,
  localparam int HW = 1 << HK
) (
  input  logic [TW-1:0] tbl,
  input  flc_mode_e     mode,
  input  logic [K-1:0]  din,
  output logic [1:0]    res
);

  logic [1:0] half_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    flc_half_lut #(.HK(HK)) u_half (
      .tbl  (tbl[h*HW +: HW]),
      .addr (din[HK-1:0]),
      .q    (half_q[h])
    );
  end

  always_comb begin
    res[1] = half_q[1];
    if (mode == MODE_SINGLE && din[K-1]) res[0] = half_q[1];
    else                                 res[0] = half_q[0];
  end

endmodule

// File: rtl/flc_out_stage.sv
module flc_out_stage #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  input  logic [N-1:0] sel,
  output logic [N-1:0] q
);

  logic [N-1:0] ff;

  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) ff[i] <= 1'b0;
      else     ff[i] <= d[i];
    end

    assign q[i] = sel[i] ? ff[i] : d[i];

    AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && sel[i]) |-> (q[i] == $past(d[i]))); // R6

    AST_COMB_PASS: assert property (@(posedge clk) disable iff (rst)
      !sel[i] |-> (q[i] == d[i])); // R7
  end

endmodule

// File: rtl/frac_lut_cell.sv
module frac_lut_cell
  import flc_pkg::*;
#(
  parameter  int K  = 6,
  localparam int TW = 1 << K
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_table,
  input  logic          cfg_mode,
  input  logic [1:0]    cfg_regsel,
  input  logic [K-1:0]  din,
  output logic [1:0]    dout
);

  logic [TW-1:0] tbl;
  flc_mode_e     mode;
  logic [1:0]    regsel;
  logic [1:0]    lut_res;

  flc_cfg_store #(.K(K), .NOUT(2)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wr_table  (cfg_table),
    .wr_mode   (cfg_mode),
    .wr_regsel (cfg_regsel),
    .tbl       (tbl),
    .mode      (mode),
    .regsel    (regsel)
  );

  flc_lut_core #(.K(K)) u_core (
    .tbl  (tbl),
    .mode (mode),
    .din  (din),
    .res  (lut_res)
  );

  flc_out_stage #(.N(2)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (lut_res),
    .sel (regsel),
    .q   (dout)
  );

  AST_SINGLE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SINGLE && din[K-1]) |-> (lut_res[0] == lut_res[1])); // R4

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == 2'b00)); // R1

endmodule

// File: tb/test_frac_lut_cell.sv
module test_frac_lut_cell;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_table = '0;
  logic        cfg_mode = 1'b0;
  logic [1:0]  cfg_regsel = '0;
  logic [5:0]  din = '0;
  logic [1:0]  dout;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [63:0] m_tbl;
  logic        m_mode;
  logic [1:0]  m_sel;
  logic [1:0]  m_prev;

  frac_lut_cell i_frac_lut_cell (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_table(cfg_table),
    .cfg_mode(cfg_mode), .cfg_regsel(cfg_regsel), .din(din), .dout(dout)
  );

  always #4 clk = ~clk;

  function automatic logic [1:0] ref_lut(input logic [63:0] t, input logic m,
                                         input logic [5:0] x);
    logic [1:0] r;
    r[0] = m ? t[x] : t[{1'b0, x[4:0]}];
    r[1] = t[{1'b1, x[4:0]}];
    return r;
  endfunction

  function automatic logic [63:0] make_table(input int k);
    logic [63:0] t;
    for (int a = 0; a < 64; a++) begin
      logic [5:0] a6;
      a6 = 6'(a);
      case (k)
        0:       t[a] = ^(a6 & 6'h2B);
        1:       t[a] = ((a % 3) == 1);
        2:       t[a] = (a >= 32) ^ a6[1];
        default: t[a] = a6[5] ^ a6[0];
      endcase
    end
    return t;
  endfunction

  task automatic cyc(input logic [5:0] x, input logic we, input logic [63:0] t,
                     input logic m, input logic [1:0] s, input logic rr,
                     input string tag);
    logic [1:0] comb;
    logic [1:0] exp;
    @(negedge clk);
    din = x; cfg_we = we; cfg_table = t; cfg_mode = m; cfg_regsel = s; rst = rr;
    #3;
    comb = ref_lut(m_tbl, m_mode, x);
    for (int i = 0; i < 2; i++) exp[i] = m_sel[i] ? m_prev[i] : comb[i];
    vectors++;
    if (dout !== exp) begin
      fails++;
      $display("FAIL %s: din=%h mode=%b sel=%b dout=%b expected %b",
               tag, x, m_mode, m_sel, dout, exp);
    end
    @(posedge clk);
    #1;
    if (rr) begin
      m_tbl = '0; m_mode = 1'b0; m_sel = '0; m_prev = '0;
    end else begin
      m_prev = comb;
      if (we) begin m_tbl = t; m_mode = m; m_sel = s; end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    m_tbl = '0; m_mode = 1'b0; m_sel = '0; m_prev = '0;
    // R1: state after reset
    for (int a = 0; a < 64; a += 9) cyc(6'(a), 1'b0, '1, 1'b1, 2'b11, 1'b0, "R1");

    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 4; s++) begin
          logic [63:0] t;
          string tg;
          t = make_table(k);
          // R8: load edge captures the old configuration's result
          cyc(6'h2A ^ 6'(k * 5 + s), 1'b1, t, m[0], s[1:0], 1'b0, "R8 R2");
          if (s != 0)      tg = "R6 R8";
          else if (m == 1) tg = "R4 R5 R7";
          else             tg = "R3 R7";
          // R2: pins change with cfg_we low and must be ignored
          for (int a = 0; a < 64; a++)
            cyc(6'(a * 37 + k), 1'b0, ~t, ~m[0], ~s[1:0], 1'b0, tg);
        end
      end
    end

    // R9: reset and load in the same cycle, reset wins
    cyc(6'h15, 1'b1, '1, 1'b1, 2'b11, 1'b1, "R9");
    for (int a = 0; a < 64; a += 5) cyc(6'(a), 1'b0, '0, 1'b0, 2'b00, 1'b0, "R9 R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule